// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block performs one of two packed multiply operations on a pair of vector operands, either 64 or 128 bits wide. The result vector always holds 16-bit lanes. In byte multiply-accumulate mode, the block works on pairs of neighbouring bytes:

- Each byte of the first operand is taken as unsigned.
- The matching byte of the second operand is taken as signed.
- The two products of each pair are added.
- The sum is clamped into one signed 16-bit word.

In rounded-scale mode, each signed 16-bit lane of one operand is multiplied by the matching lane of the other. The 32-bit product is then reduced to a Q15 result with a round-half-up step.

A caller presents both operands, an operation select and a one-cycle valid strobe. After a fixed number of clock cycles, set by a parameter, the result appears with its own valid flag. Between results the output vector holds its last value. Operands and select presented without the strobe are ignored.

Top module: `pmul_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid` is 0 and `res_data` is all zeros.
- R2: With `op_sel` = 0 (byte mode), result word i is the sum of two products. Byte 2i of `opnd_a`, read as unsigned, is multiplied by byte 2i of `opnd_b`, read as two's-complement signed. The same is done for byte 2i+1. An operand of all zeros gives an all-zero result in both modes.
- R3: In byte mode, a pair sum above 32767 becomes 0x7FFF and a pair sum below -32768 becomes 0x8000.
- R4: With `op_sel` = 1 (word mode), each lane is computed as follows:
  - Lane i of each operand (bits 16i+15..16i) is read as signed 16-bit, and the two are multiplied into a 32-bit product P.
  - T = (P arithmetically shifted right by 14) + 1.
  - Result lane i = bits 16..1 of T.
- R5: In word mode, 0x8000 times 0x8000 gives 0x8000, the wrapped value of the R4 formula.
- R6: Result word i occupies bits 16i+15..16i, so results keep the ascending order of their source pairs or lanes.
- R7: `res_valid` equals `in_valid` delayed by exactly LAT clock cycles.
- R8: When no valid result leaves the unit, `res_data` keeps its previous value. Operands and select sampled with `in_valid` low have no effect.
- R9: The parameter VEC_W = 64 yields 4 result words and VEC_W = 128 yields 8 result words, each computed by R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe, one cycle per operation |
| op_sel | input | 1 | 0 = byte multiply-accumulate, 1 = rounded word scale |
| opnd_a | input | VEC_W | First operand (unsigned bytes in byte mode) |
| opnd_b | input | VEC_W | Second operand (signed bytes in byte mode) |
| res_valid | output | 1 | High for one cycle when `res_data` carries a new result |
| res_data | output | VEC_W | Packed 16-bit result lanes |

## Verification
The bench builds two copies of the unit side by side, driven by the same stimulus:

- A 128-bit copy with LAT = 3. It exposes all eight result lanes and leaves two idle cycles between strobe and result. The bench checks in those cycles that the valid flag stays low.
- A 64-bit copy with LAT = 1. It runs from the low half of the operands, covering both the narrow lane count and the shortest pipeline.

Comparing the two copies on the same vectors shows that the lane arithmetic does not depend on vector width or on pipeline depth.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic {
        OP_BYTE_MAC  = 1'b0,
        OP_WORD_RND  = 1'b1
    } pmul_op_e;

    localparam int LANE_W = 16;

endpackage

// File: rtl/pmul_byte_lane.sv
// One result word from two unsigned x signed byte products, clamped to int16.
module pmul_byte_lane (
    input  logic [15:0] a_pair,
    input  logic [15:0] b_pair,
    output logic [15:0] res
);
    logic signed [16:0] a_lo, a_hi, b_lo, b_hi;
    logic signed [16:0] prod_lo, prod_hi;
    logic signed [17:0] pair_sum;

    always_comb begin
        a_lo = {9'b0, a_pair[7:0]};
        a_hi = {9'b0, a_pair[15:8]};
        b_lo = {{9{b_pair[7]}},  b_pair[7:0]};
        b_hi = {{9{b_pair[15]}}, b_pair[15:8]};
        prod_lo  = a_lo * b_lo;
        prod_hi  = a_hi * b_hi;
        pair_sum = {prod_lo[16], prod_lo} + {prod_hi[16], prod_hi};
        if (pair_sum > 18'sd32767)
            res = 16'h7FFF;
        else if (pair_sum < -18'sd32768)
            res = 16'h8000;
        else
            res = pair_sum[15:0];
    end
endmodule

// File: rtl/pmul_word_lane.sv
// Q15 rounded scale: ((a*b) >>> 14) + 1, then bits [16:1].
module pmul_word_lane (
    input  logic [15:0] a_lane,
    input  logic [15:0] b_lane,
    output logic [15:0] res
);
    logic signed [31:0] a_ext, b_ext, prod;
    logic        [17:0] trunc_rnd;
    logic               unused_bits;

    always_comb begin
        a_ext     = {{16{a_lane[15]}}, a_lane};
        b_ext     = {{16{b_lane[15]}}, b_lane};
        prod      = a_ext * b_ext;
        trunc_rnd = prod[31:14] + 18'd1;
        res       = trunc_rnd[16:1];
    end

    assign unused_bits = ^{trunc_rnd[17], trunc_rnd[0], prod[13:0]};
endmodule

// File: rtl/pmul_pipe.sv
// LAT-stage result pipeline; data stages load only behind a valid token.
module pmul_pipe #(
    parameter int W   = 128,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [LAT-1:0] vld_q;
    logic [W-1:0]   dat_q [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    dat_q[0] <= '0;
                end else begin
                    vld_q[0] <= in_valid;
                    if (in_valid)
                        dat_q[0] <= in_data;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    dat_q[s] <= '0;
                end else begin
                    vld_q[s] <= vld_q[s-1];
                    if (vld_q[s-1])
                        dat_q[s] <= dat_q[s-1];
                end
            end
        end
    end

    assign out_valid = vld_q[LAT-1];
    assign out_data  = dat_q[LAT-1];
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
    import pmul_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sel,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             res_valid,
    output logic [VEC_W-1:0] res_data
);
    localparam int NLANE = VEC_W / LANE_W;

    pmul_op_e         op;
    logic [VEC_W-1:0] lane_res;

    assign op = pmul_op_e'(op_sel);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [15:0] byte_res, word_res;

        pmul_byte_lane u_byte (
            .a_pair (opnd_a[LANE_W*i +: LANE_W]),
            .b_pair (opnd_b[LANE_W*i +: LANE_W]),
            .res    (byte_res)
        );

        pmul_word_lane u_word (
            .a_lane (opnd_a[LANE_W*i +: LANE_W]),
            .b_lane (opnd_b[LANE_W*i +: LANE_W]),
            .res    (word_res)
        );

        always_comb begin
            unique case (op)
                OP_BYTE_MAC: lane_res[LANE_W*i +: LANE_W] = byte_res;
                OP_WORD_RND: lane_res[LANE_W*i +: LANE_W] = word_res;
                default:     lane_res[LANE_W*i +: LANE_W] = byte_res;
            endcase
        end
    end

    pmul_pipe #(.W(VEC_W), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (lane_res),
        .out_valid (res_valid),
        .out_data  (res_data)
    );
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
    parameter int VEC_W = 128,
    parameter int LAT   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] opnd_a,
    input logic [VEC_W-1:0] opnd_b,
    input logic             res_valid,
    input logic [VEC_W-1:0] res_data
);
    logic [LAT-1:0] vsh;
    logic [LAT-1:0] zsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsh <= '0;
            zsh <= '0;
        end else begin
            for (int k = LAT - 1; k > 0; k--) begin
                vsh[k] <= vsh[k-1];
                zsh[k] <= zsh[k-1];
            end
            vsh[0] <= in_valid;
            zsh[0] <= (opnd_a == '0) || (opnd_b == '0);
        end
    end

    always @(negedge clk) begin
        if (!rst_n)
            assert_reset_clear_R1: assert (!res_valid && res_data == '0);
    end

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == vsh[LAT-1]);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    assert_zero_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && zsh[LAT-1]) |-> (res_data == '0));
endmodule

bind pmul_unit pmul_unit_chk #(.VEC_W(VEC_W), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/test_pmul_unit.sv
`timescale 1ns/1ps
module test_pmul_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sel = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         w_valid, n_valid;
    logic [127:0] w_data;
    logic [63:0]  n_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pmul_unit #(.VEC_W(128), .LAT(3)) i_pmul_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(w_valid), .res_data(w_data)
    );

    pmul_unit #(.VEC_W(64), .LAT(1)) i_pmul_unit_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a[63:0]), .opnd_b(opnd_b[63:0]), .res_valid(n_valid), .res_data(n_data)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Independent arithmetic model of the lanes
    function automatic logic [127:0] model(input logic op, input logic [127:0] a,
                                           input logic [127:0] b, input int nwords);
        logic [127:0] r = '0;
        for (int i = 0; i < nwords; i++) begin
            if (!op) begin
                int s = 0;
                for (int j = 0; j < 2; j++) begin
                    int ua = int'(a[16*i+8*j +: 8]);
                    int sb = int'($signed(b[16*i+8*j +: 8]));
                    s += ua * sb;
                end
                if (s > 32767) s = 32767;
                if (s < -32768) s = -32768;
                r[16*i +: 16] = s[15:0];
            end else begin
                longint p = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
                longint q = (p + 64'sd16384) >>> 15;
                r[16*i +: 16] = q[15:0];
            end
        end
        return r;
    endfunction

    // Issue one operation, check the latency of both copies and their results
    task automatic fire(input string tag, input logic op, input logic [127:0] a,
                        input logic [127:0] b);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R7 narrow valid after 1"}, 128'(n_valid), 128'd1);
        check({tag, " R9 narrow data"}, 128'(n_data), model(op, a, b, 4));
        check({tag, " R7 wide valid idle at 1"}, 128'(w_valid), 128'd0);
        @(negedge clk);
        check({tag, " R7 wide valid idle at 2"}, 128'(w_valid), 128'd0);
        @(negedge clk);
        check({tag, " R7 wide valid after 3"}, 128'(w_valid), 128'd1);
        check({tag, " wide data"}, w_data, model(op, a, b, 8));
        @(negedge clk);
        check({tag, " R7 wide valid one cycle"}, 128'(w_valid), 128'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 wide valid in reset", 128'(w_valid), 128'd0);
        check("R1 wide data in reset", w_data, '0);
        check("R1 narrow data in reset", 128'(n_data), '0);
        rst_n = 1'b1;
    endtask

    task automatic t_byte_basic;
        fire("R2 byte mixed", 1'b0, 128'h80FF_0102_7F03_10F0_0000_FFFF_2211_0908,
                                    128'hFF01_807F_0280_F010_1234_0101_FEFD_7F80);
        fire("R2 byte zero", 1'b0, '0, 128'hFFFF_8080_7F7F_0101_1111_2222_3333_4444);
        @(negedge clk);
        check("R2 byte zero operand gives zero", w_data, '0);
    endtask

    task automatic t_byte_sat;
        fire("R3 byte sat high", 1'b0, {16{8'hFF}}, {16{8'h7F}});
        check("R3 word0 clamps to 7FFF", 128'(w_data[15:0]), 128'h7FFF);
        fire("R3 byte sat low", 1'b0, {16{8'hFF}}, {16{8'h80}});
        check("R3 word7 clamps to 8000", 128'(w_data[127:112]), 128'h8000);
        fire("R3 byte edge", 1'b0, {8{16'h8080}}, {8{16'h7F7F}});
    endtask

    task automatic t_word;
        fire("R4 word basic", 1'b1, {8{16'h4000}}, {8{16'h4000}});
        check("R4 0x4000*0x4000 = 0x2000", 128'(w_data[31:16]), 128'h2000);
        fire("R4 word mixed", 1'b1, 128'h7FFF_8000_0001_FFFF_1234_C000_0003_7FFF,
                                    128'h7FFF_7FFF_4000_FFFF_ABCD_4000_5555_8001);
        fire("R5 word min*min", 1'b1, {8{16'h8000}}, {8{16'h8000}});
        check("R5 0x8000*0x8000 lane3", 128'(w_data[63:48]), 128'h8000);
    endtask

    task automatic t_order;
        logic [127:0] a = '0;
        logic [127:0] exp = '0;
        for (int k = 0; k < 16; k++) a[8*k +: 8] = 8'(k);
        for (int i = 0; i < 8; i++) exp[16*i +: 16] = 16'(4 * i + 1);
        fire("R6 order", 1'b0, a, {16{8'h01}});
        check("R6 ascending word order", w_data, exp);
    endtask

    task automatic t_idle;
        logic [127:0] held_w = w_data;
        logic [63:0]  held_n = n_data;
        @(negedge clk);
        op_sel = 1'b1; opnd_a = {4{32'h1357_9BDF}}; opnd_b = {4{32'h7531_ECA8}};
        repeat (5) @(negedge clk);
        check("R8 wide holds without strobe", w_data, held_w);
        check("R8 narrow holds without strobe", 128'(n_data), 128'(held_n));
        check("R8 no valid without strobe", 128'({w_valid, n_valid}), 128'd0);
    endtask

    initial begin
        t_reset();
        t_byte_basic();
        t_byte_sat();
        t_word();
        t_order();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule